// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block maps a bus address onto one of several external-memory chip selects. Every chip select owns a window word that holds a 16 MB-aligned base, a four-bit size mask and an enable flag. A device word gives the kind of device attached to that select. One shared word names a single chip select that a prefetch engine serves, and switches that engine on. For each address the decoder reports which select matches, the offset of the address inside that window, and the port that the access should use. It also raises a flag while any enabled window has a mask value that is not permitted.

The configuration is loaded through a write strobe. Each write carries a word-kind code, a chip-select index and a 32-bit data word. The decode path is combinational from the address and the stored words. A parameter can add one register stage to all decode outputs.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, chip select 0 is enabled with base 0 and mask 0xF, and every other chip select is disabled with mask 0xF. All device words and the prefetch word reset to zero. So address 0x00ABCDEF hits chip select 0 with offset 0x00ABCDEF on the NOR route, and 0x3E000000 hits nothing.
- R2: In a window word, bits [5:0] hold the base, bit 6 is the enable and bits [11:8] hold the mask. The base is compared against address bits [29:24]. Address bits above bit 29 must be zero for any hit.
- R3: Address bits [27:24] are compared against base bits [3:0] only where the mask bit is 1. The offset is the address ANDed with (0x0FFFFFFF AND NOT(mask << 24)).
- R4: The permitted mask values are 0x8, 0xC, 0xE and 0xF. The value 0x0 is also permitted when ALLOW_FULL_MASK is 1 (the default is 0). An enabled window with any other mask never matches and drives mask_err_o high. A disabled window never drives mask_err_o.
- R5: A window whose enable bit is 0 never matches.
- R6: When several windows match, only the lowest-numbered chip select is reported, and cs_hit_o has at most one bit set.
- R7: Device-word bits [11:10] equal to 2 mark a NAND device. Any other value marks a NOR-style device.
- R8: In the prefetch word, bit 7 is the enable and bits [26:24] hold the target chip select. A matched NAND window that is the enabled prefetch target takes the FIFO route. A matched NOR window keeps the NOR route even when it is the target.
- R9: route_o encoding is 0 for no hit, 1 for NOR, 2 for NAND and 3 for FIFO. With no hit, cs_hit_o is 0, route_o is 0 and the offset is 0.
- R10: The cfg_kind encoding is 0 for a window word, 1 for a device word and 2 for the prefetch word. Kind 3 writes are ignored.
- R11: With REG_OUT=1, every output follows the address one clock later. With REG_OUT=0, the outputs follow the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Word kind for the write |
| cfg_idx | input | IDX_W | Chip-select index for the write |
| cfg_wdata | input | 32 | Configuration data |
| bus_addr | input | ADDR_W | Address to decode |
| cs_hit_o | output | CS_N | One-hot matching chip select |
| win_offset_o | output | ADDR_W | Offset inside the matched window |
| route_o | output | 2 | Selected port route |
| mask_err_o | output | 1 | An enabled window has a mask that is not permitted |

## Verification
Suppose a stored window word is corrupted. The ports show it within the same cycle (or one cycle later with REG_OUT=1), as a hit on the wrong select, a changed offset width, or a mask-error flag. Suppose the priority chain or the route choice is wrong. Then overlapping windows report the higher select, or a NAND window shows the NOR or FIFO code, on the first address that falls in the overlap. The vectors are placed so that each window edge, the overlap and each route code is observed directly.

// File: rtl/cs_win_pkg.sv
package cs_win_pkg;

    typedef struct packed {
        logic [3:0] mask;
        logic       valid;
        logic [5:0] base;
    } win_cfg_t;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_NOR  = 2'd1,
        ROUTE_NAND = 2'd2,
        ROUTE_FIFO = 2'd3
    } route_t;

    typedef enum logic [1:0] {
        KIND_WIN  = 2'd0,
        KIND_DEV  = 2'd1,
        KIND_PF   = 2'd2,
        KIND_RSVD = 2'd3
    } cfg_kind_t;

    localparam logic [1:0] DEV_NAND = 2'd2;

    function automatic logic mask_ok(input logic [3:0] m, input bit allow_full);
        return (m == 4'h8) || (m == 4'hC) || (m == 4'hE) || (m == 4'hF) ||
               (allow_full && (m == 4'h0));
    endfunction

endpackage

// File: rtl/cs_win_regs.sv
module cs_win_regs
    import cs_win_pkg::*;
#(
    parameter int CS_N  = 8,
    parameter int IDX_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [1:0]                 kind,
    input  logic [IDX_W-1:0]           idx,
    input  logic [31:0]                wdata,
    output win_cfg_t [CS_N-1:0]        win_o,
    output logic [CS_N-1:0]            nand_o,
    output logic                       pf_en_o,
    output logic [IDX_W-1:0]           pf_cs_o
);

    typedef struct packed {
        win_cfg_t [CS_N-1:0]       win;
        logic [CS_N-1:0][1:0]      dev;
        logic                      pf_en;
        logic [IDX_W-1:0]          pf_cs;
    } state_t;

    state_t st_d, st_q;
    state_t st_rst;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        st_rst = '0;
        for (int i = 0; i < CS_N; i++) begin
            st_rst.win[i].mask  = 4'hF;
            st_rst.win[i].valid = (i == 0);
        end
    end

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (cfg_kind_t'(kind))
                KIND_WIN: begin
                    st_d.win[idx].base  = wdata[5:0];
                    st_d.win[idx].valid = wdata[6];
                    st_d.win[idx].mask  = wdata[11:8];
                end
                KIND_DEV: st_d.dev[idx] = wdata[11:10];
                KIND_PF: begin
                    st_d.pf_en = wdata[7];
                    st_d.pf_cs = wdata[24 +: IDX_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < CS_N; i++) nand_o[i] = (st_q.dev[i] == DEV_NAND);
    end

    assign win_o   = st_q.win;
    assign pf_en_o = st_q.pf_en;
    assign pf_cs_o = st_q.pf_cs;

    AST_RSVD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == 2'd3) |=> $stable(st_q)); // R10

endmodule

// File: rtl/cs_win_match.sv
module cs_win_match
    import cs_win_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter bit ALLOW_FULL_MASK = 1'b0
) (
    input  logic [ADDR_W-25:0] addr_hi,
    input  win_cfg_t           cfg,
    output logic               hit_o,
    output logic               bad_o
);

    localparam int HI_W = ADDR_W - 24;

    logic legal, top_zero, base_eq;

    generate
        if (HI_W > 6) begin : g_top
            assign top_zero = (addr_hi[HI_W-1:6] == '0);
        end else begin : g_notop
            assign top_zero = 1'b1;
        end
    endgenerate

    assign legal   = mask_ok(cfg.mask, ALLOW_FULL_MASK);
    assign base_eq = (addr_hi[5:4] == cfg.base[5:4]) &&
                     (((addr_hi[3:0] ^ cfg.base[3:0]) & cfg.mask) == 4'h0);
    assign hit_o   = cfg.valid && legal && top_zero && base_eq;
    assign bad_o   = cfg.valid && !legal;

endmodule

// File: rtl/cs_win_pick.sv
module cs_win_pick
    import cs_win_pkg::*;
#(
    parameter int CS_N  = 8,
    parameter int IDX_W = 3
) (
    input  logic [CS_N-1:0]  hit_vec,
    input  logic [CS_N-1:0]  nand_vec,
    input  logic             pf_en,
    input  logic [IDX_W-1:0] pf_cs,
    output logic [CS_N-1:0]  onehot_o,
    output logic [IDX_W-1:0] sel_o,
    output logic             any_o,
    output route_t           route_o
);

    always_comb begin
        any_o    = 1'b0;
        sel_o    = '0;
        onehot_o = '0;
        for (int i = 0; i < CS_N; i++) begin
            if (hit_vec[i] && !any_o) begin
                any_o       = 1'b1;
                sel_o       = IDX_W'(i);
                onehot_o[i] = 1'b1;
            end
        end
        if (!any_o)                          route_o = ROUTE_NONE;
        else if (!nand_vec[sel_o])           route_o = ROUTE_NOR;
        else if (pf_en && pf_cs == sel_o)    route_o = ROUTE_FIFO;
        else                                 route_o = ROUTE_NAND;
    end

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import cs_win_pkg::*;
#(
    parameter int  CS_N            = 8,
    parameter int  ADDR_W          = 32,
    parameter bit  ALLOW_FULL_MASK = 1'b0,
    parameter bit  REG_OUT         = 1'b0,
    localparam int IDX_W           = $clog2(CS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [CS_N-1:0]   cs_hit_o,
    output logic [ADDR_W-1:0] win_offset_o,
    output logic [1:0]        route_o,
    output logic              mask_err_o
);

    typedef struct packed {
        logic [CS_N-1:0]   hit;
        logic [ADDR_W-1:0] off;
        route_t            route;
        logic              err;
    } out_t;

    win_cfg_t [CS_N-1:0] win;
    logic [CS_N-1:0]     nand_vec, hit_vec, bad_vec, onehot;
    logic                pf_en, any;
    logic [IDX_W-1:0]    pf_cs, sel;
    route_t              route;
    out_t                out_d, out_q;

    cs_win_regs #(.CS_N(CS_N), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(cfg_kind), .idx(cfg_idx),
        .wdata(cfg_wdata), .win_o(win), .nand_o(nand_vec),
        .pf_en_o(pf_en), .pf_cs_o(pf_cs)
    );

    generate
        for (genvar g = 0; g < CS_N; g++) begin : g_match
            cs_win_match #(.ADDR_W(ADDR_W), .ALLOW_FULL_MASK(ALLOW_FULL_MASK)) u_match (
                .addr_hi(bus_addr[ADDR_W-1:24]), .cfg(win[g]),
                .hit_o(hit_vec[g]), .bad_o(bad_vec[g])
            );
        end
    endgenerate

    cs_win_pick #(.CS_N(CS_N), .IDX_W(IDX_W)) u_pick (
        .hit_vec(hit_vec), .nand_vec(nand_vec), .pf_en(pf_en), .pf_cs(pf_cs),
        .onehot_o(onehot), .sel_o(sel), .any_o(any), .route_o(route)
    );

    always_comb begin
        logic [ADDR_W-1:0] keep;
        keep        = '0;
        keep[27:0]  = {~win[sel].mask, 24'hFF_FFFF};
        out_d.hit   = onehot;
        out_d.off   = any ? (bus_addr & keep) : '0;
        out_d.route = route;
        out_d.err   = |bad_vec;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign cs_hit_o     = out_q.hit;
    assign win_offset_o = out_q.off;
    assign route_o      = out_q.route;
    assign mask_err_o   = out_q.err;

    AST_HIT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_hit_o)); // R6
    AST_IDLE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hit_o == '0) |-> (route_o == 2'd0 && win_offset_o == '0)); // R9
    AST_FIFO_NEEDS_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        (route == ROUTE_FIFO) |-> (pf_en && nand_vec[pf_cs])); // R8
    AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (out_d.off[ADDR_W-1:28] == '0)); // R3
    AST_BAD_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & bad_vec) == '0); // R4

endmodule

// File: tb/cs_window_decoder_bench.sv
module cs_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = 2'd0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] bus_addr = 32'd0;

    logic [7:0]  hit_c, hit_r;
    logic [31:0] off_c, off_r;
    logic [1:0]  rt_c, rt_r;
    logic        err_c, err_r;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cs_window_decoder u_cs_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .bus_addr(bus_addr),
        .cs_hit_o(hit_c), .win_offset_o(off_c), .route_o(rt_c), .mask_err_o(err_c)
    );

    cs_window_decoder #(.REG_OUT(1'b1)) u_cs_window_decoder_reg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .bus_addr(bus_addr),
        .cs_hit_o(hit_r), .win_offset_o(off_r), .route_o(rt_r), .mask_err_o(err_r)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  hit;
        logic [31:0] off;
        logic [1:0]  route;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{32'h0012_3456, 8'h01, 32'h0012_3456, 2'd1},
        '{32'h05AB_CDEF, 8'h02, 32'h01AB_CDEF, 2'd2},
        '{32'h07FF_FFFF, 8'h02, 32'h03FF_FFFF, 2'd2},
        '{32'h0800_0000, 8'h00, 32'h0000_0000, 2'd0},
        '{32'h1700_0010, 8'h04, 32'h0700_0010, 2'd1},
        '{32'h1800_0000, 8'h40, 32'h0000_0000, 2'd3},
        '{32'h18FF_FFFF, 8'h40, 32'h00FF_FFFF, 2'd3},
        '{32'h1900_0000, 8'h00, 32'h0000_0000, 2'd0},
        '{32'h3E00_0004, 8'h80, 32'h0000_0004, 2'd1},
        '{32'h3FFF_FFFF, 8'h80, 32'h01FF_FFFF, 2'd1},
        '{32'h7E00_0004, 8'h00, 32'h0000_0000, 2'd0},
        '{32'h3000_0000, 8'h00, 32'h0000_0000, 2'd0},
        '{32'h0400_0000, 8'h02, 32'h0000_0000, 2'd2},
        '{32'h0100_0000, 8'h00, 32'h0000_0000, 2'd0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        look(32'h00AB_CDEF);
        chk("R1 reset hit", {24'd0, hit_c}, 32'h01);
        chk("R1 reset offset", off_c, 32'h00AB_CDEF);
        chk("R1 reset route", {30'd0, rt_c}, 32'd1);
        chk("R1 reset mask err", {31'd0, err_c}, 32'd0);
        look(32'h3E00_0000);
        chk("R1 reset other cs off", {24'd0, hit_c}, 32'h00);

        // R10 program windows, device kinds and prefetch
        wr(2'd0, 3'd1, 32'h0000_0C44);
        wr(2'd0, 3'd2, 32'h0000_0850);
        wr(2'd0, 3'd3, 32'h0000_0F45);
        wr(2'd0, 3'd5, 32'h0000_0E30);
        wr(2'd0, 3'd6, 32'h0000_0F58);
        wr(2'd0, 3'd7, 32'h0000_0E7F);
        wr(2'd1, 3'd1, 32'h0000_0800);
        wr(2'd1, 3'd3, 32'h0000_0800);
        wr(2'd1, 3'd6, 32'h0000_0800);
        wr(2'd2, 3'd0, 32'h0600_0080);

        for (int i = 0; i < NV; i++) begin
            look(VEC[i].addr);
            chk("R2 R5 R6 table hit", {24'd0, hit_c}, {24'd0, VEC[i].hit});
            chk("R3 table offset", off_c, VEC[i].off);
            chk("R7 R8 R9 table route", {30'd0, rt_c}, {30'd0, VEC[i].route});
            chk("R11 table registered hit", {24'd0, hit_r}, {24'd0, VEC[i].hit});
            chk("R11 table registered offset", off_r, VEC[i].off);
        end

        // R4 illegal masks
        wr(2'd0, 3'd4, 32'h0000_0360);
        look(32'h2000_0000);
        chk("R4 bad mask flag", {31'd0, err_c}, 32'd1);
        chk("R4 bad mask no hit", {24'd0, hit_c}, 32'h00);
        wr(2'd0, 3'd4, 32'h0000_0060);
        look(32'h2000_0000);
        chk("R4 full mask not allowed flag", {31'd0, err_c}, 32'd1);
        chk("R4 full mask not allowed hit", {24'd0, hit_c}, 32'h00);
        wr(2'd0, 3'd4, 32'h0000_0320);
        look(32'h2000_0000);
        chk("R4 disabled bad mask no flag", {31'd0, err_c}, 32'd0);
        wr(2'd0, 3'd4, 32'h0000_0F60);
        look(32'h2000_0000);
        chk("R4 fixed mask hit", {24'd0, hit_c}, 32'h10);
        chk("R4 fixed mask flag", {31'd0, err_c}, 32'd0);

        // R8 prefetch off, then aimed at a NOR window
        wr(2'd2, 3'd0, 32'h0000_0006);
        look(32'h1800_0000);
        chk("R8 engine off gives NAND", {30'd0, rt_c}, 32'd2);
        wr(2'd2, 3'd0, 32'h0200_0080);
        look(32'h1000_0000);
        chk("R8 NOR target stays NOR", {30'd0, rt_c}, 32'd1);
        look(32'h1800_0000);
        chk("R8 other NAND not FIFO", {30'd0, rt_c}, 32'd2);

        // R10 reserved kind ignored
        wr(2'd3, 3'd0, 32'h0000_0000);
        look(32'h0000_0010);
        chk("R10 reserved kind ignored hit", {24'd0, hit_c}, 32'h01);
        chk("R10 reserved kind ignored offset", off_c, 32'h0000_0010);

        // R11 latency
        look(32'h3FFF_FFFF);
        @(negedge clk);
        bus_addr = 32'h0000_0020;
        #1;
        chk("R11 comb follows now", {24'd0, hit_c}, 32'h01);
        chk("R11 reg still old", {24'd0, hit_r}, 32'h80);
        @(posedge clk);
        @(negedge clk);
        chk("R11 reg after edge", {24'd0, hit_r}, 32'h01);
        chk("R11 reg offset after edge", off_r, 32'h0000_0020);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule